// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line-Level Override

This block serializes bytes from a small write-side FIFO onto a single serial output line. Each byte goes out as one asynchronous frame: a low start bit, the data bits least significant first, then a high stop bit. Every bit lasts `OVS` periods of an external baud tick. A transmit-enable input gates the serializer. While the enable is low, the line is no longer driven by the serializer. It follows two software-held port bits instead: a drive bit and a level bit.

Software uses the override in two ways. It can hold the line at mark (high) before it turns transmission on. It can also send a break: it lowers the level bit first and then drops the enable. Dropping the enable re-initializes the serializer in the same cycle, even in the middle of a frame. The shift register and the counters are cleared, and the byte in flight is discarded. Bytes still waiting in the FIFO are kept, and the next frame starts only after the enable is raised again. Two flags report progress. The empty flag rises when the FIFO level drops to a programmable threshold or below it. The end flag rises when the last stop bit has finished and the FIFO holds nothing.

The serializer is a four-state machine. In `ST_IDLE` the line is high. When the enable is high and the FIFO holds a byte, the machine pops the byte and moves to `ST_START`. After one bit time it moves from `ST_START` to `ST_DATA`. After the last data bit it moves from `ST_DATA` to `ST_STOP`. After the stop bit it moves from `ST_STOP` back to `ST_IDLE`. From any state, a low enable forces `ST_IDLE` at the next clock.

Top module: `uart_brk_tx`

## Requirements
- R1: A frame is a start bit of 0, then DATA_W data bits least significant first, then a stop bit of 1. Each bit lasts OVS baud ticks, and the line idles at 1 between frames.
- R2: A frame starts only while tx_en is 1 and the FIFO holds at least one byte. Queued bytes are sent in write order.
- R3: While tx_en is 0: with port_dir = 1, txd equals port_dat and txd_oe is 1. With port_dir = 0, txd_oe is 0 and txd rests at 1.
- R4: Clearing tx_en in mid-frame hands txd to the port bits in that same cycle. With port_dir = 1 and port_dat = 0, txd stays at a continuous 0 (break) for as long as tx_en remains 0.
- R5: An aborted frame's byte is lost and no frame starts while tx_en is 0. Bytes still queued stay in the FIFO and are sent in full once tx_en returns to 1.
- R6: fifo_empty is 1 exactly when the FIFO level is less than or equal to empty_thr.
- R7: tx_end is 1 after reset. It goes to 1 when a stop bit completes with the FIFO empty. It goes to 0 on the cycle after a write is accepted. An aborted frame does not set it.
- R8: A write while the FIFO holds FIFO_DEPTH bytes is ignored, and the stored bytes are unaffected.
- R9: After reset the FIFO is empty, fifo_empty is 1, tx_end is 1 and the serializer is idle.
- R10: Bit timing advances only on cycles with baud_tick = 1. With no ticks the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse; OVS of these make one bit time |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DATA_W | Byte to queue |
| tx_en | input | 1 | Transmit enable; 0 aborts and re-initializes the serializer |
| port_dir | input | 1 | Override drive bit used while tx_en is 0 |
| port_dat | input | 1 | Override line level used while tx_en is 0 |
| empty_thr | input | LVL_W | Level at or below which fifo_empty is raised |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Output enable for txd |
| fifo_empty | output | 1 | FIFO level at or below empty_thr |
| tx_end | output | 1 | Last stop bit done and FIFO empty |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and OVS = 4. Short bit times keep mid-bit sampling and abort timing within a few hundred cycles. A four-entry FIFO can be filled to overflow by a handful of writes. It also lets a threshold of 2 separate the empty flag from the true empty state, and leaves a second byte queued behind an aborted frame. Dividing the baud tick by three, and holding it off entirely, shows that bit timing follows the tick rather than the clock.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/ubt_fifo.sv
module ubt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [LVL_W-1:0] level,
    output logic             wr_ok
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          rd_ok;

    assign wr_ok   = wr_en && (level != LVL_W'(DEPTH));
    assign rd_ok   = rd_en && (level != '0);
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + LVL_W'(wr_ok) - LVL_W'(rd_ok);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && wr_en && !rd_en) |=> (level == LVL_W'(DEPTH)));
endmodule

// File: rtl/ubt_serializer.sv
module ubt_serializer #(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         tx_en,
    input  logic         fifo_has,
    input  logic [W-1:0] fifo_data,
    output logic         pop,
    output logic         ser_bit,
    output logic         frame_done
);
    import ubt_pkg::*;

    localparam int TCW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BCW = (W > 1) ? $clog2(W) : 1;

    tx_state_e      state, state_nx;
    logic [TCW-1:0] tick_cnt;
    logic [BCW-1:0] bit_idx;
    logic [W-1:0]   shreg;
    logic           bit_end;

    assign bit_end = baud_tick && (tick_cnt == TCW'(OVS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_en && fifo_has) state_nx = ST_START;
            ST_START: if (bit_end) state_nx = ST_DATA;
            ST_DATA:  if (bit_end && bit_idx == BCW'(W - 1)) state_nx = ST_STOP;
            ST_STOP:  if (bit_end) state_nx = ST_IDLE;
        endcase
        if (!tx_en) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (!tx_en) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (pop) begin
            shreg    <= fifo_data;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (state != ST_IDLE && baud_tick) begin
            if (bit_end) begin
                tick_cnt <= '0;
                if (state == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= (bit_idx == BCW'(W - 1)) ? '0 : bit_idx + 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pop        = 1'b0;
        frame_done = 1'b0;
        ser_bit    = 1'b1;
        unique case (state)
            ST_IDLE:  pop = tx_en && fifo_has;
            ST_START: ser_bit = 1'b0;
            ST_DATA:  ser_bit = shreg[0];
            ST_STOP:  frame_done = bit_end && tx_en;
        endcase
    end

    // R4
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state == ST_IDLE));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(tx_en && fifo_has)) |=> (state == ST_IDLE));
    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !baud_tick && state != ST_IDLE) |=> $stable(state));
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              port_dir,
    input  logic              port_dat,
    input  logic [LVL_W-1:0]  empty_thr,
    output logic              txd,
    output logic              txd_oe,
    output logic              fifo_empty,
    output logic              tx_end
);
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;
    logic              wr_ok, pop, ser_bit, frame_done;

    ubt_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head), .level(level), .wr_ok(wr_ok)
    );

    ubt_serializer #(.W(DATA_W), .OVS(OVS)) u_ser (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .fifo_has(level != '0), .fifo_data(head), .pop(pop),
        .ser_bit(ser_bit), .frame_done(frame_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          tx_end <= 1'b1;
        else if (wr_ok)                      tx_end <= 1'b0;
        else if (frame_done && level == '0)  tx_end <= 1'b1;
    end

    assign fifo_empty = (level <= empty_thr);
    assign txd        = tx_en ? ser_bit : (port_dir ? port_dat : 1'b1);
    assign txd_oe     = tx_en | port_dir;

    // R7
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !tx_end);
    // R7
    end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> (level == '0));
endmodule

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;
    localparam int W = 8, DEPTH = 4, OVS = 4;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0, tx_en = 0;
    logic port_dir = 0, port_dat = 0;
    logic [W-1:0]  wr_data = '0;
    logic [LW-1:0] empty_thr = '0;
    logic txd, txd_oe, fifo_empty, tx_end;
    int checks = 0, errors = 0;
    int div = 1;
    bit tick_on = 1;
    bit done = 0;

    uart_brk_tx #(.DATA_W(W), .FIFO_DEPTH(DEPTH), .OVS(OVS)) i_uart_brk_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .tx_en(tx_en), .port_dir(port_dir), .port_dat(port_dat),
        .empty_thr(empty_thr), .txd(txd), .txd_oe(txd_oe),
        .fifo_empty(fifo_empty), .tx_end(tx_end)
    );

    always #4 clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1 >= div) ? 0 : c + 1;
            baud_tick = tick_on && (c == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [W-1:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic recv(output logic [W-1:0] b, output bit ok);
        int bt = OVS * div;
        int t = 0;
        ok = 0; b = '0;
        while (txd !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
        if (t >= 2000) return;
        cyc(bt / 2);
        chk(txd == 0, "R1 start", txd, 0);
        for (int k = 0; k < W; k++) begin
            cyc(bt);
            b[k] = txd;
        end
        cyc(bt);
        chk(txd == 1, "R1 stop", txd, 1);
        ok = 1;
    endtask

    task automatic t_reset;
        chk(fifo_empty == 1, "R9 fifo_empty", fifo_empty, 1);
        chk(tx_end == 1, "R9 tx_end", tx_end, 1);
        chk(txd == 1 && txd_oe == 0, "R9/R3 idle line", {txd, txd_oe}, 2'b10);
    endtask

    task automatic t_mark;
        port_dir = 1; port_dat = 1; cyc(1);
        chk(txd == 1 && txd_oe == 1, "R3 mark", {txd, txd_oe}, 2'b11);
        port_dat = 0; cyc(1);
        chk(txd == 0 && txd_oe == 1, "R3 low", {txd, txd_oe}, 2'b01);
        port_dir = 0; cyc(1);
        chk(txd == 1 && txd_oe == 0, "R3 undriven", {txd, txd_oe}, 2'b10);
        port_dir = 1; port_dat = 1; cyc(1);
    endtask

    task automatic t_frames;
        logic [W-1:0] b; bit ok;
        tx_en = 1;
        push(8'hA5); push(8'h3C);
        chk(tx_end == 0, "R7 cleared by write", tx_end, 0);
        recv(b, ok); chk(ok && b == 8'hA5, "R1 byte A5", b, 8'hA5);
        recv(b, ok); chk(ok && b == 8'h3C, "R2 order 3C", b, 8'h3C);
        cyc(OVS * div + 2);
        chk(tx_end == 1, "R7 end set", tx_end, 1);
        chk(txd == 1, "R1 idle high", txd, 1);
    endtask

    task automatic t_break;
        logic [W-1:0] b; bit ok; int t = 0; bit allz = 1;
        tx_en = 1; push(8'h81); push(8'h5A);
        while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
        cyc(3 * OVS * div);
        port_dat = 0; cyc(1);
        tx_en = 0; #1;
        chk(txd == 0 && txd_oe == 1, "R4 break same cycle", {txd, txd_oe}, 2'b01);
        for (int i = 0; i < 30; i++) begin cyc(1); if (txd !== 0) allz = 0; end
        chk(allz, "R4 continuous break", allz, 1);
        chk(fifo_empty == 0, "R5 queue kept", fifo_empty, 0);
        chk(tx_end == 0, "R7 abort no end", tx_end, 0);
        port_dat = 1; cyc(10);
        chk(txd == 1, "R5 no start while disabled", txd, 1);
        tx_en = 1;
        recv(b, ok); chk(ok && b == 8'h5A, "R5 resumed byte", b, 8'h5A);
        cyc(OVS * div + 2);
        chk(tx_end == 1 && fifo_empty == 1, "R5 drained", {tx_end, fifo_empty}, 2'b11);
    endtask

    task automatic t_thr_full;
        logic [W-1:0] b; bit ok;
        tx_en = 0; empty_thr = 2;
        push(8'h11); push(8'h22);
        chk(fifo_empty == 1, "R6 level 2 thr 2", fifo_empty, 1);
        push(8'h33);
        chk(fifo_empty == 0, "R6 level 3 thr 2", fifo_empty, 0);
        push(8'h44); push(8'h55);
        empty_thr = 3; cyc(1);
        chk(fifo_empty == 0, "R8 level full", fifo_empty, 0);
        empty_thr = 0; tx_en = 1;
        recv(b, ok); chk(b == 8'h11, "R8 byte1", b, 8'h11);
        recv(b, ok); chk(b == 8'h22, "R8 byte2", b, 8'h22);
        recv(b, ok); chk(b == 8'h33, "R8 byte3", b, 8'h33);
        recv(b, ok); chk(b == 8'h44, "R8 byte4", b, 8'h44);
        cyc(3 * OVS * div);
        chk(txd == 1 && tx_end == 1, "R8 dropped fifth", {txd, tx_end}, 2'b11);
    endtask

    task automatic t_tick;
        logic [W-1:0] b; bit ok;
        div = 3; tx_en = 1;
        push(8'h96);
        recv(b, ok); chk(ok && b == 8'h96, "R10 divided tick", b, 8'h96);
        cyc(OVS * div + 4);
        tick_on = 0; push(8'hF0);
        cyc(60);
        chk(txd == 0, "R10 held start without tick", txd, 0);
        tick_on = 1;
        recv(b, ok);
        cyc(OVS * div + 4);
        chk(tx_end == 1, "R10 frame finishes after ticks resume", tx_end, 1);
        div = 1;
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(2);
        t_reset; t_mark; t_frames; t_break; t_thr_full; t_tick;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule